// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block watches the receive side of a 10BASE-T twisted-pair port and decides whether the link is alive. It takes two kinds of receive evidence: a receive-data activity level and a one-cycle event for each link test pulse that has already passed shape qualification. If neither kind of evidence arrives within a loss window, the block declares the link failed. A failed link drives `link_ok` low, and the surrounding port uses that to gate its transmit, receive and loopback paths. Link pulses that arrive sooner than a minimum spacing after the previous accepted pulse are rejected.

While the link is failed, the block counts link pulses that are properly spaced. It returns through a hold state once it has counted enough pulses or once receive data appears. From the hold state it goes back to normal testing only after both receive and transmit have gone quiet.

Independently of link state, the block requests a link pulse at a fixed interval while the transmitter is idle. All windows are counted in ticks of a 1 ms tick-enable input, and every window is set by a parameter. A low enable input switches the test off and forces a permanent link pass.

Top module: `lit_monitor`

## Requirements
- R1: After reset, `lnk_state` is 2'b00 (testing), `lp_req` is 0, and `link_ok` is 1.
- R2: In state 2'b00, the loss timer counts ticks of `tick_ms`. It is restarted by `rx_busy` or by an accepted pulse. When it has reached LOSS_TICKS, and the current cycle has `rx_busy` low and no accepted pulse, the next state is 2'b01 (failed).
- R3: In state 2'b00, a `lp_seen` event that comes before MIN_TICKS ticks have passed since entry or since the last accepted pulse is ignored. It does not restart the loss timer.
- R4: `link_ok` is low whenever `link_en` is high and `lnk_state` is not 2'b00.
- R5: In state 2'b01, each accepted pulse increments a pulse count, which starts at zero on entry, and restarts both spacing timers. When the count reaches LP_NEED, the next state is 2'b10 (hold). State 2'b01 never goes directly to 2'b00 while enabled.
- R6: In state 2'b01, the pulse count returns to zero on an early pulse, or when MAX_TICKS ticks have elapsed with `rx_busy` low.
- R7: In state 2'b01, `rx_busy` high moves the block to state 2'b10 in the next cycle.
- R8: State 2'b10 stays put while `rx_busy` or `tx_busy` is high. It returns to 2'b00 in the cycle after both are low.
- R9: `lp_req` is raised in the cycle after every LP_PERIOD-th tick, counted while `link_en` is high, `lb_force` is low and `tx_busy` is low. The count restarts whenever any of those three conditions fails.
- R10: `lp_req` is never high in two consecutive cycles.
- R11: With `link_en` low, `link_ok` is high in that same cycle. The state returns to 2'b00 at the next edge, with all timers and the count cleared, and no failure can occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle 1 ms tick enable for all windows |
| link_en | input | 1 | Link test enable |
| rx_busy | input | 1 | Receive data activity present |
| lp_seen | input | 1 | One-cycle qualified receive link pulse |
| tx_busy | input | 1 | Transmit output active |
| lb_force | input | 1 | Forced internal loopback, suppresses pulse requests |
| link_ok | output | 1 | Link pass; low gates transmit, receive and loopback |
| lnk_state | output | 2 | 00 testing, 01 failed, 10 hold |
| lp_req | output | 1 | One-cycle request to emit a link pulse |

## Verification
Several events can land on the same edge: the loss timer expiring, a link pulse arriving, and a tick. An accepted pulse on the expiry cycle must rescue the link, but an early pulse on that cycle must not. The random phase drives pulses, ticks and receive activity densely enough that these coincidences occur repeatedly, next to directed pulses placed at exact tick counts. Each outcome is judged against a cycle model in the bench that is derived from the requirements.

// File: rtl/lit_pkg.sv
package lit_pkg;

  typedef enum logic [1:0] {
    LS_UP   = 2'b00,
    LS_DOWN = 2'b01,
    LS_HOLD = 2'b10
  } lnk_st_e;

  // saturating tick step
  function automatic int unsigned tick_adv(int unsigned v, int unsigned lim, logic adv);
    return (adv && v < lim) ? v + 1 : v;
  endfunction

  function automatic logic at_limit(int unsigned v, int unsigned lim);
    return v >= lim;
  endfunction

  function automatic logic need_met(int unsigned cnt_after, int unsigned need);
    return cnt_after >= need;
  endfunction

  function automatic logic period_hit(int unsigned v, int unsigned per);
    return v + 1 >= per;
  endfunction

endpackage

// File: rtl/lit_tick_timer.sv
module lit_tick_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] lim,
  output logic [TW-1:0] cnt,
  output logic          done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= TW'(lit_pkg::tick_adv(32'(cnt), 32'(lim), tick));
  end

  assign done = lit_pkg::at_limit(32'(cnt), 32'(lim));
endmodule

// File: rtl/lit_link_fsm.sv
module lit_link_fsm #(
  parameter int LP_NEED = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                link_en,
  input  logic                rx_busy,
  input  logic                tx_busy,
  input  logic                lp_seen,
  input  logic                main_done,
  input  logic                min_done,
  output lit_pkg::lnk_st_e    st,
  output logic                clr_main,
  output logic                clr_min
);
  import lit_pkg::*;
  localparam int CW = $clog2(LP_NEED + 1);

  lnk_st_e        st_nxt;
  logic [CW-1:0]  cnt, cnt_nxt, cnt_inc;
  logic           lp_acc, lp_early;

  assign lp_acc   = lp_seen && min_done;
  assign lp_early = lp_seen && !min_done;
  assign cnt_inc  = cnt + CW'(1);

  always_comb begin
    st_nxt   = st;
    cnt_nxt  = cnt;
    clr_main = 1'b0;
    clr_min  = 1'b0;
    if (!link_en) begin
      st_nxt = LS_UP; cnt_nxt = '0; clr_main = 1'b1; clr_min = 1'b1;
    end else begin
      unique case (st)
        LS_UP: begin
          if (main_done && !rx_busy && !lp_acc) begin
            st_nxt = LS_DOWN; cnt_nxt = '0; clr_main = 1'b1; clr_min = 1'b1;
          end else begin
            clr_main = lp_acc || rx_busy;
            clr_min  = lp_acc;
          end
        end
        LS_DOWN: begin
          if (rx_busy) begin
            st_nxt = LS_HOLD; clr_main = 1'b1; clr_min = 1'b1;
          end else if (lp_acc) begin
            clr_main = 1'b1; clr_min = 1'b1;
            if (need_met(32'(cnt_inc), LP_NEED)) st_nxt = LS_HOLD;
            else                                 cnt_nxt = cnt_inc;
          end else if (lp_early || main_done) begin
            cnt_nxt = '0; clr_main = 1'b1; clr_min = 1'b1;
          end
        end
        LS_HOLD: begin
          clr_main = 1'b1; clr_min = 1'b1;
          if (!rx_busy && !tx_busy) st_nxt = LS_UP;
        end
        default: begin
          st_nxt = LS_UP; clr_main = 1'b1; clr_min = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= LS_UP;
      cnt <= '0;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/lit_lp_gen.sv
module lit_lp_gen #(
  parameter int LP_PERIOD = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  output logic lp_req
);
  localparam int PW = $clog2(LP_PERIOD + 1);
  logic [PW-1:0] pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; lp_req <= 1'b0;
    end else if (!run) begin
      pc <= '0; lp_req <= 1'b0;
    end else if (tick) begin
      if (lit_pkg::period_hit(32'(pc), LP_PERIOD)) begin
        pc <= '0; lp_req <= 1'b1;
      end else begin
        pc <= pc + PW'(1); lp_req <= 1'b0;
      end
    end else begin
      lp_req <= 1'b0;
    end
  end
endmodule

// File: rtl/lit_monitor.sv
module lit_monitor #(
  parameter int LOSS_TICKS = 100,
  parameter int MIN_TICKS  = 4,
  parameter int MAX_TICKS  = 100,
  parameter int LP_NEED    = 2,
  parameter int LP_PERIOD  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       link_en,
  input  logic       rx_busy,
  input  logic       lp_seen,
  input  logic       tx_busy,
  input  logic       lb_force,
  output logic       link_ok,
  output logic [1:0] lnk_state,
  output logic       lp_req
);
  import lit_pkg::*;
  localparam int BIG  = (LOSS_TICKS > MAX_TICKS) ? LOSS_TICKS : MAX_TICKS;
  localparam int TOP  = (BIG > MIN_TICKS) ? BIG : MIN_TICKS;
  localparam int TW   = $clog2(TOP + 1);

  lnk_st_e       st;
  logic          clr_main, clr_min, main_done, min_done, min_dummy_unused;
  logic [TW-1:0] main_cnt, min_cnt, main_lim;

  assign main_lim = (st == LS_UP) ? TW'(LOSS_TICKS) : TW'(MAX_TICKS);
  assign min_dummy_unused = |min_cnt;

  lit_tick_timer #(.TW(TW)) u_main (
    .clk(clk), .rst_n(rst_n), .clr(clr_main), .tick(tick_ms),
    .lim(main_lim), .cnt(main_cnt), .done(main_done)
  );

  lit_tick_timer #(.TW(TW)) u_min (
    .clk(clk), .rst_n(rst_n), .clr(clr_min), .tick(tick_ms),
    .lim(TW'(MIN_TICKS)), .cnt(min_cnt), .done(min_done)
  );

  lit_link_fsm #(.LP_NEED(LP_NEED)) u_fsm (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .rx_busy(rx_busy),
    .tx_busy(tx_busy), .lp_seen(lp_seen), .main_done(main_done),
    .min_done(min_done), .st(st), .clr_main(clr_main), .clr_min(clr_min)
  );

  lit_lp_gen #(.LP_PERIOD(LP_PERIOD)) u_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms),
    .run(link_en && !lb_force && !tx_busy), .lp_req(lp_req)
  );

  assign lnk_state = st;
  assign link_ok   = !link_en || (st == LS_UP);
endmodule

// File: rtl/lit_monitor_chk.sv
module lit_monitor_chk #(
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          link_en,
  input logic          rx_busy,
  input logic          tx_busy,
  input logic          lp_seen,
  input logic          tick_ms,
  input logic          link_ok,
  input logic          lp_req,
  input logic [1:0]    st,
  input logic [TW-1:0] main_cnt,
  input logic          main_done,
  input logic          min_done
);
  assert_loss_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b00 && link_en && main_done && !rx_busy && !(lp_seen && min_done))
      |=> st == 2'b01);

  assert_early_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b00 && link_en && lp_seen && !min_done && !rx_busy && tick_ms && !main_done)
      |=> main_cnt != '0);

  assert_no_direct_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b01 && link_en) |=> st != 2'b00);

  assert_hold_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b10 && link_en && (rx_busy || tx_busy)) |=> st == 2'b10);

  assert_lp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |=> !lp_req);

  assert_disable_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> (st == 2'b00 && main_cnt == '0));
endmodule

bind lit_monitor lit_monitor_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .link_en(link_en), .rx_busy(rx_busy),
  .tx_busy(tx_busy), .lp_seen(lp_seen), .tick_ms(tick_ms),
  .link_ok(link_ok), .lp_req(lp_req), .st(lnk_state),
  .main_cnt(main_cnt), .main_done(main_done), .min_done(min_done)
);

// File: tb/sim_lit_monitor.sv
module sim_lit_monitor;
  localparam int CLK_NS = 10;
  localparam int LOSS = 12, MINS = 3, MAXS = 15, NEED = 2, PER = 5;

  logic clk = 0, rst_n = 0;
  logic tick_ms = 0, link_en = 0, rx_busy = 0, lp_seen = 0, tx_busy = 0, lb_force = 0;
  logic link_ok, lp_req;
  logic [1:0] lnk_state;

  always #(CLK_NS/2) clk = ~clk;

  lit_monitor #(.LOSS_TICKS(LOSS), .MIN_TICKS(MINS), .MAX_TICKS(MAXS),
                .LP_NEED(NEED), .LP_PERIOD(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .link_en(link_en),
    .rx_busy(rx_busy), .lp_seen(lp_seen), .tx_busy(tx_busy), .lb_force(lb_force),
    .link_ok(link_ok), .lnk_state(lnk_state), .lp_req(lp_req)
  );

  int total = 0, fails = 0;
  bit finished = 0;
  string tg = "R1";
  int pend_st = -1;
  string pend_tag = "";
  logic prev_req = 0;

  // bench model, derived from the requirements
  int m_st = 0, m_a = 0, m_m = 0, m_c = 0, m_pc = 0;
  bit m_req = 0, m_en = 0;

  function automatic int grow(int v, int lim, bit t);
    if (t && v < lim) return v + 1;
    return v;
  endfunction

  function automatic bit expect_ok(int st, bit en);
    return !en || st == 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    check(lnk_state == m_st[1:0], tg, lnk_state, m_st);
    check(link_ok == expect_ok(m_st, m_en), tg, link_ok, expect_ok(m_st, m_en));
    check(lp_req == m_req, "R9", lp_req, m_req);
    if (lp_req) check(!prev_req, "R10", prev_req, 0);
    prev_req = lp_req;
    if (pend_st >= 0) begin
      check(lnk_state == pend_st[1:0], pend_tag, lnk_state, pend_st);
      if (m_en) check(link_ok == (pend_st == 0), "R4", link_ok, pend_st == 0);
      pend_st = -1;
    end
  endtask

  task automatic advance(bit e, bit rx, bit tx, bit lb, bit lp, bit tk);
    int lim;
    bit mdone, mmin, acc;
    lim = (m_st == 0) ? LOSS : MAXS;
    mdone = m_a >= lim;
    mmin = m_m >= MINS;
    acc = lp && mmin;
    if (!e) begin
      m_st = 0; m_a = 0; m_m = 0; m_c = 0;
    end else if (m_st == 0) begin
      if (mdone && !rx && !acc) begin
        m_st = 1; m_a = 0; m_m = 0; m_c = 0;
      end else begin
        m_a = (acc || rx) ? 0 : grow(m_a, lim, tk);
        m_m = acc ? 0 : grow(m_m, MINS, tk);
      end
    end else if (m_st == 1) begin
      if (rx) begin
        m_st = 2; m_a = 0; m_m = 0;
      end else if (acc) begin
        m_a = 0; m_m = 0;
        if (m_c + 1 >= NEED) m_st = 2; else m_c++;
      end else if (lp || mdone) begin
        m_c = 0; m_a = 0; m_m = 0;
      end else begin
        m_a = grow(m_a, lim, tk);
        m_m = grow(m_m, MINS, tk);
      end
    end else begin
      m_a = 0; m_m = 0;
      if (!rx && !tx) m_st = 0;
    end
    if (!e || lb || tx) begin
      m_pc = 0; m_req = 0;
    end else if (tk) begin
      if (m_pc == PER - 1) begin m_pc = 0; m_req = 1; end
      else begin m_pc++; m_req = 0; end
    end else m_req = 0;
    m_en = e;
  endtask

  task automatic cyc(bit e, bit rx, bit tx, bit lb, bit lp, bit tk);
    @(negedge clk);
    compare();
    link_en = e; rx_busy = rx; tx_busy = tx; lb_force = lb; lp_seen = lp; tick_ms = tk;
    advance(e, rx, tx, lb, lp, tk);
  endtask

  task automatic run(int n, bit e, bit rx, bit tx, bit lb, int lpk);
    for (int i = 0; i < n; i++)
      cyc(e, rx, tx, lb, (lpk != 0) && (i % lpk == lpk - 1), 1'b1);
  endtask

  task automatic want(string req, int st);
    pend_tag = req; pend_st = st;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    tg = "R1";
    run(3, 1, 0, 1, 0, 0);
    // R2: silence until loss window closes (timers started at first enabled edge)
    tg = "R2";
    run(9, 1, 0, 1, 0, 0);
    want("R2", 0);
    run(1, 1, 0, 1, 0, 0);
    run(2, 1, 0, 1, 0, 0);
    want("R2", 1);
    run(1, 1, 0, 1, 0, 0);
    // R6: early pulses and max-spacing expiry keep the count at zero
    tg = "R6";
    run(20, 1, 0, 1, 0, 2);
    want("R6", 1);
    run(40, 1, 0, 1, 0, 0);
    cyc(1, 0, 1, 0, 1, 1);
    run(20, 1, 0, 1, 0, 0);
    cyc(1, 0, 1, 0, 1, 1);
    want("R6", 1);
    // R5: second well-spaced pulse reaches the need
    tg = "R5";
    run(3, 1, 0, 1, 0, 0);
    cyc(1, 0, 1, 0, 1, 1);
    want("R5", 2);
    // R8: hold waits for both sides quiet
    tg = "R8";
    run(5, 1, 0, 1, 0, 0);
    want("R8", 2);
    run(1, 1, 1, 0, 0, 0);
    run(1, 1, 0, 0, 0, 0);
    want("R8", 0);
    // R3: an early pulse does not restart the loss window
    tg = "R3";
    cyc(1, 0, 1, 0, 1, 1);
    run(12, 1, 0, 1, 0, 0);
    want("R3", 1);
    // R7: receive data while failed
    tg = "R7";
    run(2, 1, 1, 1, 0, 0);
    want("R7", 2);
    run(3, 1, 1, 1, 0, 0);
    run(1, 1, 0, 0, 0, 0);
    // R11: disabling forces pass
    tg = "R11";
    run(16, 1, 0, 1, 0, 0);
    run(1, 0, 0, 1, 0, 0);
    want("R11", 0);
    run(30, 0, 0, 0, 0, 2);
    // R9: periodic requests, suppressed by loopback and transmit
    tg = "R9";
    run(25, 1, 1, 0, 0, 0);
    run(12, 1, 1, 0, 1, 0);
    run(8, 1, 1, 1, 0, 0);
    run(14, 1, 1, 0, 0, 0);
    // R4: constrained random mix
    tg = "R4";
    for (int i = 0; i < 5000; i++) begin
      bit e, rx, tx, lb, lp, tk;
      e  = ($urandom % 40) != 0;
      rx = ($urandom % 9) == 0;
      tx = ($urandom % 3) == 0;
      lb = ($urandom % 12) == 0;
      lp = ($urandom % 4) == 0;
      tk = ($urandom % 3) != 0;
      cyc(e, rx, tx, lb, lp, tk);
    end
    cyc(1, 0, 1, 0, 0, 1);
    finished = 1;
    summary();
    $finish;
  end
endmodule